// File: doc/BRIEF.md
# Performance Counter Bank with Privileged Read Port

This block holds a set of free-running 40-bit event counters, eighteen by default. Each counter has its own event input and its own enable bit. While the counter is enabled, each clock with its event input high adds one to it, and the count rolls over to zero after its largest value. A plain configuration write port loads a new count and enable bit into one counter. Only requests carrying privilege level zero may use it, and a load wins over an increment in the same cycle.

Software reads a counter through a request/response stream port. A request carries a 32-bit select word and the requester's context: a privilege level, a protected-mode flag and a flag that lets unprivileged code read. The low 31 bits of the select word give the counter index. Bit 31 asks for a fast read: only the low 32 bits of the count, with the high word zeroed. Otherwise the read returns all 40 bits, split over two 32-bit words. A read with an index out of range, or one that the context does not permit, returns a fault flag with zero data.

Both read channels use valid/ready. A request is taken on a clock edge where `rd_valid` and `rd_ready` are both high. Its response appears on `rsp_valid` after that edge and stays unchanged until a clock edge with `rsp_ready` high. `rd_ready` is high whenever the response register is empty or is being drained in the same cycle, so one request can be accepted in every cycle.

Top module: `pmc_bank`

## Requirements
- R1: After a synchronous active-high reset, every count and enable bit is zero, `rsp_valid` is low and `rd_ready` is high.
- R2: An enabled counter adds one on each clock edge where its event input is high. A disabled counter keeps its value, whatever its event input does.
- R3: A counter holding 2^40-1 goes to 0 on its next increment. A carry out of bit 31 reaches bit 32.
- R4: A write with `wr_valid` high, `wr_cpl` equal to 0 and `wr_idx` below the counter count loads `wr_value` and `wr_enable` into that counter, taking priority over an increment in the same cycle. A write with any other `wr_cpl` changes no counter.
- R5: A full read (select bit 31 = 0) returns count bits 31..0 in `rsp_lo`, and count bits 39..32 in `rsp_hi` bits 7..0, with `rsp_hi` bits 31..8 zero.
- R6: A fast read (select bit 31 = 1) returns count bits 31..0 in `rsp_lo` and a zero `rsp_hi`.
- R7: If select bits 30..0, all decoded as one unsigned number, are 18 or more, the response has `rsp_fault` = 1 and both data words zero.
- R8: A read is permitted when `rd_user_en` is 1, when `rd_cpl` is 0, or when `rd_prot` is 0. Any other combination faults with zero data.
- R9: A request accepted at a clock edge gives `rsp_valid` = 1 after that edge. The response holds stable while `rsp_ready` is low. `rd_ready` equals NOT `rsp_valid` OR `rsp_ready`.
- R10: The returned count is the value the counter held just before the accepting edge; an increment at that same edge is not included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NUM_CTR | Per-counter event inputs, sampled each clock |
| wr_valid | input | 1 | Configuration write strobe |
| wr_cpl | input | CPL_W | Privilege level of the write |
| wr_idx | input | IDX_W | Counter targeted by the write |
| wr_value | input | CTR_W | Count value to load |
| wr_enable | input | 1 | Enable bit to load |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_sel | input | SEL_W | Select word: bit 31 fast read, bits 30..0 index |
| rd_cpl | input | CPL_W | Privilege level of the reader |
| rd_prot | input | 1 | Reader is in protected mode |
| rd_user_en | input | 1 | Unprivileged reads allowed |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_fault | output | 1 | Response is a fault |
| rsp_hi | output | WORD_W | High result word |
| rsp_lo | output | WORD_W | Low result word |

## Verification
Some properties are checked on every cycle. The response handshake must stay stable under back-pressure and the ready rule must hold. A faulting response must carry zero data, and the high word may use only its low eight bits. An accepted request with a bad index, or with a context that is not allowed, must produce a fault, and a fast request must produce a zero high word. Other behaviours depend on the exact count and can be shown only by the bench's scenarios. These include the count after a run of events, rollover and carry into bit 32, a write beating an increment, ignored unprivileged writes, and the rule that a read returns the value from before the accepting edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned PMC_NUM_DEF  = 18;
  localparam int unsigned PMC_CTR_DEF  = 40;
  localparam int unsigned PMC_SEL_DEF  = 32;
  localparam int unsigned PMC_WORD_DEF = 32;
  localparam int unsigned PMC_CPL_DEF  = 2;

  // Outcome of the read-permission and index decode
  typedef enum logic [1:0] {
    ACC_FULL = 2'd0,
    ACC_FAST = 2'd1,
    ACC_DENY = 2'd2
  } pmc_acc_e;
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int CTR_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [CTR_W-1:0] ld_val,
  input  logic             ld_enable,
  input  logic             evt,
  output logic [CTR_W-1:0] count_o
);
  logic             run_q;
  logic [CTR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (ld_en) begin
      cnt_q <= ld_val;
      run_q <= ld_enable;
    end else if (run_q && evt) begin
      cnt_q <= cnt_q + CTR_W'(1);
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pmc_access_check.sv
module pmc_access_check
  import pmc_pkg::*;
#(
  parameter int NUM_CTR = 18,
  parameter int SEL_W   = 32,
  parameter int CPL_W   = 2,
  parameter int IDX_W   = 5
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [CPL_W-1:0] cpl,
  input  logic             prot,
  input  logic             user_en,
  output logic [IDX_W-1:0] idx_o,
  output pmc_acc_e         kind_o
);
  localparam int NUM_W = SEL_W - 1;

  logic [NUM_W-1:0] num;
  logic             in_range;
  logic             allowed;

  // The whole index field takes part in the range test
  assign num      = sel[NUM_W-1:0];
  assign in_range = (num < NUM_W'(NUM_CTR));
  assign allowed  = user_en || (cpl == '0) || !prot;
  assign idx_o    = num[IDX_W-1:0];

  always_comb begin
    if (!in_range || !allowed) kind_o = ACC_DENY;
    else if (sel[SEL_W-1])     kind_o = ACC_FAST;
    else                       kind_o = ACC_FULL;
  end
endmodule

// File: rtl/pmc_read_port.sv
module pmc_read_port
  import pmc_pkg::*;
#(
  parameter int NUM_CTR = 18,
  parameter int CTR_W   = 40,
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CTR*CTR_W-1:0] counts,
  input  logic                     accept,
  input  logic [IDX_W-1:0]         idx,
  input  pmc_acc_e                 kind,
  input  logic                     rsp_ready,
  output logic                     rsp_valid,
  output logic                     rsp_fault,
  output logic [WORD_W-1:0]        rsp_hi,
  output logic [WORD_W-1:0]        rsp_lo
);
  logic [CTR_W-1:0]  pick;
  logic [WORD_W-1:0] hi_n;
  logic [WORD_W-1:0] lo_n;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (idx == IDX_W'(i)) pick = counts[i*CTR_W +: CTR_W];
    end
  end

  always_comb begin
    hi_n = '0;
    lo_n = '0;
    unique case (kind)
      ACC_FULL: begin
        hi_n = WORD_W'(pick >> WORD_W);
        lo_n = WORD_W'(pick);
      end
      ACC_FAST: lo_n = WORD_W'(pick);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_hi    <= '0;
      rsp_lo    <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_fault <= (kind == ACC_DENY);
      rsp_hi    <= hi_n;
      rsp_lo    <= lo_n;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int NUM_CTR = PMC_NUM_DEF,
  parameter int CTR_W   = PMC_CTR_DEF,
  parameter int SEL_W   = PMC_SEL_DEF,
  parameter int WORD_W  = PMC_WORD_DEF,
  parameter int CPL_W   = PMC_CPL_DEF,
  parameter int IDX_W   = $clog2(NUM_CTR)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CTR-1:0] evt_in,
  input  logic               wr_valid,
  input  logic [CPL_W-1:0]   wr_cpl,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [CTR_W-1:0]   wr_value,
  input  logic               wr_enable,
  input  logic               rd_valid,
  output logic               rd_ready,
  input  logic [SEL_W-1:0]   rd_sel,
  input  logic [CPL_W-1:0]   rd_cpl,
  input  logic               rd_prot,
  input  logic               rd_user_en,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault,
  output logic [WORD_W-1:0]  rsp_hi,
  output logic [WORD_W-1:0]  rsp_lo
);
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;
  logic                     wr_ok;
  logic                     accept;
  logic [IDX_W-1:0]         rd_idx;
  pmc_acc_e                 rd_kind;

  assign wr_ok    = wr_valid && (wr_cpl == '0) && (32'(wr_idx) < NUM_CTR);
  assign rd_ready = !rsp_valid || rsp_ready;
  assign accept   = rd_valid && rd_ready;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    pmc_counter #(.CTR_W(CTR_W)) u_ctr (
      .clk       (clk),
      .rst       (rst),
      .ld_en     (wr_ok && (wr_idx == IDX_W'(g))),
      .ld_val    (wr_value),
      .ld_enable (wr_enable),
      .evt       (evt_in[g]),
      .count_o   (cnt_flat[g*CTR_W +: CTR_W])
    );
  end

  pmc_access_check #(
    .NUM_CTR(NUM_CTR), .SEL_W(SEL_W), .CPL_W(CPL_W), .IDX_W(IDX_W)
  ) u_acc (
    .sel     (rd_sel),
    .cpl     (rd_cpl),
    .prot    (rd_prot),
    .user_en (rd_user_en),
    .idx_o   (rd_idx),
    .kind_o  (rd_kind)
  );

  pmc_read_port #(
    .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .WORD_W(WORD_W), .IDX_W(IDX_W)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .counts    (cnt_flat),
    .accept    (accept),
    .idx       (rd_idx),
    .kind      (rd_kind),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_hi    (rsp_hi),
    .rsp_lo    (rsp_lo)
  );
endmodule

// File: rtl/pmc_bank_checker.sv
module pmc_bank_checker #(
  parameter int NUM_CTR = 18,
  parameter int CTR_W   = 40,
  parameter int SEL_W   = 32,
  parameter int WORD_W  = 32,
  parameter int CPL_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [SEL_W-1:0]  rd_sel,
  input logic [CPL_W-1:0]  rd_cpl,
  input logic              rd_prot,
  input logic              rd_user_en,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_fault,
  input logic [WORD_W-1:0] rsp_hi,
  input logic [WORD_W-1:0] rsp_lo
);
  localparam int HI_BITS = (CTR_W > WORD_W) ? CTR_W - WORD_W : 0;

  logic take;
  logic bad_idx;
  logic bad_priv;
  assign take     = rd_valid && rd_ready;
  assign bad_idx  = rd_sel[SEL_W-2:0] >= (SEL_W-1)'(NUM_CTR);
  assign bad_priv = rd_prot && (rd_cpl != '0) && !rd_user_en;

  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> rd_ready); // R9
  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (rst)
    take |=> rsp_valid); // R9
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) && $stable(rsp_hi) && $stable(rsp_lo))); // R9
  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_hi == '0 && rsp_lo == '0)); // R7
  AST_HI_WIDTH: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_hi >> HI_BITS) == '0)); // R5
  AST_FAST_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    (take && rd_sel[SEL_W-1]) |=> (rsp_hi == '0)); // R6
  AST_BAD_INDEX: assert property (@(posedge clk) disable iff (rst)
    (take && bad_idx) |=> rsp_fault); // R7
  AST_PRIV_DENY: assert property (@(posedge clk) disable iff (rst)
    (take && bad_priv) |=> rsp_fault); // R8
  AST_PRIV_GRANT: assert property (@(posedge clk) disable iff (rst)
    (take && !bad_priv && !bad_idx) |=> !rsp_fault); // R8
endmodule

bind pmc_bank pmc_bank_checker #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .SEL_W(SEL_W), .WORD_W(WORD_W), .CPL_W(CPL_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_sel     (rd_sel),
  .rd_cpl     (rd_cpl),
  .rd_prot    (rd_prot),
  .rd_user_en (rd_user_en),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_fault  (rsp_fault),
  .rsp_hi     (rsp_hi),
  .rsp_lo     (rsp_lo)
);

// File: tb/pmc_bank_bench.sv
`timescale 1ns/1ps
module pmc_bank_bench;
  localparam int N = 18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] evt_in = '0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_cpl = '0;
  logic [4:0]  wr_idx = '0;
  logic [39:0] wr_value = '0;
  logic        wr_enable = 1'b0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [31:0] rd_sel = '0;
  logic [1:0]  rd_cpl = '0;
  logic        rd_prot = 1'b0;
  logic        rd_user_en = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_fault;
  logic [31:0] rsp_hi;
  logic [31:0] rsp_lo;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pmc_bank u_pmc_bank (
    .clk(clk), .rst(rst), .evt_in(evt_in),
    .wr_valid(wr_valid), .wr_cpl(wr_cpl), .wr_idx(wr_idx),
    .wr_value(wr_value), .wr_enable(wr_enable),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_sel(rd_sel),
    .rd_cpl(rd_cpl), .rd_prot(rd_prot), .rd_user_en(rd_user_en),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_hi(rsp_hi), .rsp_lo(rsp_lo)
  );

  function automatic logic [39:0] pat(int i);
    logic [31:0] m;
    m = 32'h9E37_79B9 * 32'(i + 1);
    return {8'(i * 13 + 5), m};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input int idx, input logic [39:0] val, input logic en, input logic [1:0] cpl);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = 5'(idx); wr_value = val; wr_enable = en; wr_cpl = cpl;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [31:0] sel, input logic [1:0] cpl, input logic prot,
                         input logic ue, output logic f, output logic [31:0] hi, output logic [31:0] lo);
    @(negedge clk);
    rd_valid = 1'b1; rd_sel = sel; rd_cpl = cpl; rd_prot = prot; rd_user_en = ue; rsp_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R9 response after accept", 64'(rsp_valid), 64'd1);
    f = rsp_fault; hi = rsp_hi; lo = rsp_lo;
  endtask

  task automatic expect_full(input int i, input logic [39:0] v, input string req);
    logic f; logic [31:0] hi, lo;
    do_read(32'(i), 2'd0, 1'b1, 1'b0, f, hi, lo);
    chk(!f && hi == {24'b0, v[39:32]} && lo == v[31:0], req, {f, 7'b0, hi[23:0], lo}, {8'b0, 24'b0, v});
  endtask

  task automatic expect_fast(input int i, input logic [39:0] v, input string req);
    logic f; logic [31:0] hi, lo;
    do_read(32'h8000_0000 | 32'(i), 2'd0, 1'b1, 1'b0, f, hi, lo);
    chk(!f && hi == 32'd0 && lo == v[31:0], req, {f, 31'b0, lo} | {hi, 32'b0}, {32'b0, v[31:0]});
  endtask

  task automatic expect_fault(input logic [31:0] sel, input string req);
    logic f; logic [31:0] hi, lo;
    do_read(sel, 2'd0, 1'b0, 1'b0, f, hi, lo);
    chk(f && hi == 0 && lo == 0, req, {31'b0, f, lo} | {hi, 32'b0}, 64'd1);
  endtask

  task automatic run_all();
    logic f; logic [31:0] hi, lo; logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid === 1'b0, "R1 rsp_valid low", 64'(rsp_valid), 64'd0);
    chk(rd_ready === 1'b1, "R1 rd_ready high", 64'(rd_ready), 64'd1);
    for (int i = 0; i < N; i++) expect_full(i, 40'd0, "R1 count zero");
    // R1 enable zero: events do not count
    evt_in = '1;
    repeat (4) @(negedge clk);
    evt_in = '0;
    expect_full(6, 40'd0, "R1 enable cleared");

    // R4/R5/R6 load every counter and sweep both read modes
    for (int i = 0; i < N; i++) do_write(i, pat(i), 1'b0, 2'd0);
    for (int i = 0; i < N; i++) expect_full(i, pat(i), "R5 full read");
    for (int i = 0; i < N; i++) expect_fast(i, pat(i), "R6 fast read");

    // R7 index sweep, whole field decoded
    for (int s = N; s <= 40; s++) expect_fault(32'(s), "R7 index past end");
    expect_fault(32'h0001_0000, "R7 bit16 set");
    expect_fault(32'h4000_0003, "R7 bit30 set");
    expect_fault(32'h8000_0012, "R7 fast index 18");
    expect_fault(32'h7FFF_FFFF, "R7 all index bits");
    expect_fast(17, pat(17), "R7 fast last index");

    // R8 privilege sweep on counter 5
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 2; p++)
        for (int u = 0; u < 2; u++) begin
          logic [39:0] v;
          logic deny;
          v = pat(5);
          deny = (p == 1) && (c != 0) && (u == 0);
          do_read(32'd5, 2'(c), 1'(p), 1'(u), f, hi, lo);
          if (deny) chk(f && hi == 0 && lo == 0, "R8 denied", {31'b0, f, lo}, 64'd1);
          else chk(!f && hi == {24'b0, v[39:32]} && lo == v[31:0], "R8 granted", {f, 7'b0, hi[23:0], lo}, {32'b0, v[31:0]} | {24'b0, v[39:32], 32'b0});
        end

    // R4 unprivileged write ignored
    do_write(4, 40'h12_3456_789A, 1'b1, 2'd2);
    do_write(4, 40'h12_3456_789A, 1'b1, 2'd3);
    expect_full(4, pat(4), "R4 write at cpl!=0 ignored");

    // R2 counting, enabled vs disabled
    do_write(2, 40'd100, 1'b1, 2'd0);
    @(negedge clk); evt_in[2] = 1'b1;
    repeat (10) @(negedge clk);
    evt_in[2] = 1'b0;
    expect_full(2, 40'd110, "R2 ten events counted");
    @(negedge clk); evt_in[7] = 1'b1;
    repeat (10) @(negedge clk);
    evt_in[7] = 1'b0;
    expect_full(7, pat(7), "R2 disabled holds");

    // R4 write beats increment
    @(negedge clk);
    evt_in[2] = 1'b1; wr_valid = 1'b1; wr_idx = 5'd2; wr_value = 40'd500; wr_enable = 1'b1; wr_cpl = 2'd0;
    @(negedge clk);
    wr_valid = 1'b0; evt_in[2] = 1'b0;
    expect_full(2, 40'd500, "R4 load wins over increment");

    // R3 rollover and carry into bit 32
    do_write(9, 40'hFF_FFFF_FFFF, 1'b1, 2'd0);
    @(negedge clk); evt_in[9] = 1'b1;
    @(negedge clk); evt_in[9] = 1'b0;
    expect_full(9, 40'd0, "R3 rollover to zero");
    do_write(10, 40'h00_FFFF_FFFF, 1'b1, 2'd0);
    @(negedge clk); evt_in[10] = 1'b1;
    @(negedge clk); evt_in[10] = 1'b0;
    expect_full(10, 40'h01_0000_0000, "R3 carry into bit 32");
    expect_fast(10, 40'h01_0000_0000, "R3 fast read after carry");

    // R10 read sees value before the accepting edge
    @(negedge clk);
    evt_in[2] = 1'b1; wr_valid = 1'b1; wr_idx = 5'd2; wr_value = 40'd1000; wr_enable = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    rd_valid = 1'b1; rd_sel = 32'd2; rd_cpl = 2'd0; rd_prot = 1'b1; rd_user_en = 1'b0;
    @(negedge clk);
    rd_valid = 1'b0; evt_in[2] = 1'b0;
    chk(rsp_valid && !rsp_fault && rsp_lo == 32'd1000, "R10 pre-edge value", 64'(rsp_lo), 64'd1000);
    expect_full(2, 40'd1001, "R10 increment kept");

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; rd_valid = 1'b1; rd_sel = 32'd0; rd_cpl = 2'd0; rd_prot = 1'b0;
    @(negedge clk);
    chk(rsp_valid && rsp_lo == pat(0)[31:0], "R9 first response", 64'(rsp_lo), 64'(pat(0)[31:0]));
    chk(rd_ready === 1'b0, "R9 ready low while full", 64'(rd_ready), 64'd0);
    held = rsp_lo;
    rd_sel = 32'd1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_lo == held && !rd_ready, "R9 response held", 64'(rsp_lo), 64'(held));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rsp_valid && rsp_lo == pat(1)[31:0], "R9 next request after drain", 64'(rsp_lo), 64'(pat(1)[31:0]));
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9 drained", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule